// File: doc/BRIEF.md
# Buffer Descriptor List DMA Walker

This block handles one audio stream whose data is described by a list of buffer descriptors held in memory. Each descriptor is 16 bytes long and names one data buffer: where it sits, how many bytes it holds, and whether finishing it should raise an interrupt. On a start pulse the walker either loads a new descriptor from the list or carries on with the one it already holds. It then requests that buffer's bytes over a simple memory request port. Every request is no larger than the stream FIFO.

A start with `resume` low is a fresh fetch. The walker reads descriptor `start_idx` from `list_base + start_idx*16`, clears its byte offset, and moves up to `req_bytes` bytes. A start with `resume` high skips the fetch and continues from the saved offset. In both cases the transfer is clipped to the bytes still left in the buffer. A one-cycle `done` pulse ends each run. With it come a refused-fetch flag, an error flag, the number of bytes moved, and whether the descriptor is now complete and needs an interrupt. The sample data itself goes to whatever sits on the memory port; this block only sequences the requests.

Top module: `bdl_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `xfer_bytes` are all zero.
- R2: A fresh start with `list_base` equal to zero makes no memory request. One cycle later it gives `done` together with `not_found`, and `desc_complete` stays low.
- R3: A fresh fetch issues four 4-byte reads at `list_base + idx*16` plus 0, 4, 8 and 12. Word 0 is the low half of the buffer address, word 1 is the high half, word 2 is the length in bytes, and bit 0 of word 3 is the interrupt flag. The other bits of word 3 are ignored. After a successful fetch, `cur_index` shows the index.
- R4: A fresh fetch resets the byte offset to zero, even if the previous run had stopped partway into the buffer.
- R5: A run moves min(requested bytes, length minus offset) bytes, and reports that count on `xfer_bytes`.
- R6: Data requests have `mem_len` no larger than FIFO_BYTES. They start at the buffer address plus the offset, and each one begins where the previous one ended.
- R7: A start with `resume` high makes no descriptor reads and continues from the current offset.
- R8: At `done`, `desc_complete` is high when the length is zero or the offset has reached the length. A zero-length descriptor makes no data request.
- R9: `irq_needed` is high only when `desc_complete` is high and the descriptor's interrupt flag is set.
- R10: A memory response with `mem_err` high ends the run on the next cycle with `xfer_err` set. `xfer_bytes` then counts only the chunks that were accepted before the error.
- R11: `busy` is high from the cycle after an accepted start until the `done` cycle. A start pulse that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| resume | input | 1 | With start: continue the held descriptor instead of fetching |
| list_base | input | AW | Descriptor list base byte address |
| start_idx | input | IW | Descriptor index to fetch |
| req_bytes | input | LW | Bytes requested for this run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| not_found | output | 1 | With done: fetch refused because the base was zero |
| xfer_err | output | 1 | With done: a memory access failed |
| desc_complete | output | 1 | With done: the descriptor buffer is exhausted |
| irq_needed | output | 1 | With done: complete and the interrupt flag is set |
| xfer_bytes | output | LW | Bytes moved in the last run |
| cur_index | output | IW | Index of the last successfully fetched descriptor |
| mem_req | output | 1 | Memory request valid, held until acknowledged |
| mem_addr | output | AW | Request byte address |
| mem_len | output | CW | Request length in bytes |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_err | input | 1 | With mem_ack: the access failed |
| mem_rdata | input | 32 | Read word returned with mem_ack |

## Verification
Most internal faults in this block show up on the memory port at the very first request that follows them. A mis-latched base, index or fetch-word counter gives a wrong `mem_addr` on a descriptor read. A stale offset or a wrong remaining count gives a wrong address or length on the next data chunk. Faults in the completion logic or the interrupt flag only appear at the `done` pulse, and only for descriptors that reach their end or carry the flag. The runs therefore mix complete and partial buffers, zero-length buffers, flagged and unflagged descriptors, and resumed runs.

// File: rtl/bdl_walker.sv
module bdl_walker #(
  parameter int AW         = 64,
  parameter int LW         = 32,
  parameter int IW         = 8,
  parameter int FIFO_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          resume,
  input  logic [AW-1:0] list_base,
  input  logic [IW-1:0] start_idx,
  input  logic [LW-1:0] req_bytes,
  output logic          busy,
  output logic          done,
  output logic          not_found,
  output logic          xfer_err,
  output logic          desc_complete,
  output logic          irq_needed,
  output logic [LW-1:0] xfer_bytes,
  output logic [IW-1:0] cur_index,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [$clog2(FIFO_BYTES+1)-1:0] mem_len,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata
);
  localparam int CW         = $clog2(FIFO_BYTES+1);
  localparam int DESC_BYTES = 16;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_DONE} st_t;
  st_t st;

  logic [AW-1:0] base_q, buf_q;
  logic [IW-1:0] idx_q, cur_q;
  logic [1:0]    word_q;
  logic [LW-1:0] req_q, len_q, off_q, rem_q, moved_q;
  logic          ioc_q, valid_q, nf_q, err_q;
  logic [LW-1:0] chunk, left;

  function automatic logic [LW-1:0] lmin(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign left     = len_q - off_q;
  assign chunk    = (rem_q > LW'(FIFO_BYTES)) ? LW'(FIFO_BYTES) : rem_q;
  assign mem_req  = (st == S_FETCH) || (st == S_XFER && rem_q != '0);
  assign mem_addr = (st == S_FETCH) ? base_q + AW'(idx_q) * AW'(DESC_BYTES) + (AW'(word_q) << 2)
                                    : buf_q + AW'(off_q);
  assign mem_len  = (st == S_FETCH) ? CW'(4) : chunk[CW-1:0];

  assign busy          = (st == S_FETCH) || (st == S_XFER);
  assign done          = (st == S_DONE);
  assign not_found     = done && nf_q;
  assign xfer_err      = done && err_q;
  assign desc_complete = done && valid_q && (len_q == '0 || off_q >= len_q);
  assign irq_needed    = desc_complete && ioc_q;
  assign xfer_bytes    = moved_q;
  assign cur_index     = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_q <= '0; buf_q <= '0; idx_q <= '0; cur_q <= '0; word_q <= '0;
      req_q <= '0; len_q <= '0; off_q <= '0; rem_q <= '0; moved_q <= '0;
      ioc_q <= 1'b0; valid_q <= 1'b0; nf_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          nf_q <= 1'b0;
          err_q <= 1'b0;
          moved_q <= '0;
          req_q <= req_bytes;
          if (resume) begin
            rem_q <= valid_q ? lmin(req_bytes, left) : '0;
            st <= S_XFER;
          end else begin
            valid_q <= 1'b0;
            base_q <= list_base;
            idx_q <= start_idx;
            word_q <= '0;
            if (list_base == '0) begin
              nf_q <= 1'b1;
              st <= S_DONE;
            end else begin
              st <= S_FETCH;
            end
          end
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st <= S_DONE;
          end else begin
            word_q <= word_q + 2'd1;
            case (word_q)
              2'd0: buf_q[31:0] <= mem_rdata;
              2'd1: buf_q[AW-1:32] <= mem_rdata[AW-33:0];
              2'd2: len_q <= LW'(mem_rdata);
              default: begin
                ioc_q <= mem_rdata[0];
                off_q <= '0;
                valid_q <= 1'b1;
                cur_q <= idx_q;
                rem_q <= lmin(req_q, len_q);
                st <= S_XFER;
              end
            endcase
          end
        end
        S_XFER: begin
          if (rem_q == '0) st <= S_DONE;
          else if (mem_ack) begin
            if (mem_err) begin
              err_q <= 1'b1;
              st <= S_DONE;
            end else begin
              off_q <= off_q + chunk;
              moved_q <= moved_q + chunk;
              rem_q <= rem_q - chunk;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_fetch_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |-> (base_q != '0));

  assert_chunk_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && mem_req) |-> (mem_len != '0 && LW'(mem_len) <= LW'(FIFO_BYTES) && LW'(mem_len) <= rem_q));

  assert_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && valid_q) |-> (rem_q <= len_q - off_q));

  assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && mem_req && mem_ack && !mem_err) |=> (moved_q == $past(moved_q) + LW'($past(mem_len))));

  assert_off_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (off_q <= len_q));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_needed |-> desc_complete);

  assert_stop_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_req && mem_ack && mem_err) |=> (done && xfer_err));

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (busy || done));
endmodule

// File: tb/bdl_walker_tb.sv
module bdl_walker_tb_top;
  localparam int AW = 64, LW = 32, IW = 8, FB = 16;
  localparam int CW = $clog2(FB+1);
  localparam logic [63:0] BASE = 64'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, resume = 1'b0;
  logic [AW-1:0] list_base = '0;
  logic [IW-1:0] start_idx = '0;
  logic [LW-1:0] req_bytes = '0;
  logic busy, done, not_found, xfer_err, desc_complete, irq_needed;
  logic [LW-1:0] xfer_bytes;
  logic [IW-1:0] cur_index;
  logic mem_req, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] mem_len;
  logic [31:0] mem_rdata;

  always #5 clk = ~clk;

  bdl_walker #(.AW(AW), .LW(LW), .IW(IW), .FIFO_BYTES(FB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .list_base(list_base),
    .start_idx(start_idx), .req_bytes(req_bytes), .busy(busy), .done(done),
    .not_found(not_found), .xfer_err(xfer_err), .desc_complete(desc_complete),
    .irq_needed(irq_needed), .xfer_bytes(xfer_bytes), .cur_index(cur_index),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata));

  logic [31:0] mem [0:31];
  logic [63:0] d_addr [0:3];
  logic [31:0] d_len  [0:3];
  logic        d_ioc  [0:3];
  logic slow = 1'b0, stall_t = 1'b0;
  logic [63:0] err_addr = '1;

  always @(posedge clk) stall_t <= ~stall_t;
  always_comb begin
    mem_ack   = mem_req && !(slow && stall_t);
    mem_err   = mem_ack && (mem_addr == err_addr);
    mem_rdata = (mem_addr >= BASE && mem_addr < BASE + 64'd128) ? mem[mem_addr[6:2]] : 32'h0;
  end

  int checks = 0, errors = 0;
  logic [71:0] exp_q [$];

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      logic [71:0] got, e;
      got = {mem_addr, 8'(mem_len)};
      if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected request", longint'(got[71:8]), 0);
      else begin
        e = exp_q.pop_front();
        chk(got == e, "R3/R6", "request addr/len", longint'(got[71:8]) * 256 + got[7:0],
            longint'(e[71:8]) * 256 + e[7:0]);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [63:0] m_addr = '0;
  logic [31:0] m_len = '0, m_off = '0;
  logic m_ioc = 1'b0, m_valid = 1'b0;
  int m_idx = 0;

  task automatic run(input logic [63:0] base, input int idx, input int req, input bit res, input bit glitch);
    bit nf = 0, err = 0, comp, irq;
    int moved = 0, n = 0, rem;
    if (!res) begin
      m_valid = 0;
      if (base == 0) nf = 1;
      else begin
        for (int w = 0; w < 4; w++) begin
          logic [63:0] a;
          a = base + 64'(idx) * 16 + 64'(w) * 4;
          exp_q.push_back({a, 8'd4});
          if (a == err_addr) begin err = 1; break; end
        end
        if (!err) begin
          m_addr = d_addr[idx]; m_len = d_len[idx]; m_ioc = d_ioc[idx];
          m_off = 0; m_valid = 1; m_idx = idx;
        end
      end
    end
    if (!nf && !err) begin
      rem = m_valid ? ((req < int'(m_len - m_off)) ? req : int'(m_len - m_off)) : 0;
      while (rem > 0) begin
        int c;
        logic [63:0] a;
        c = (rem > FB) ? FB : rem;
        a = m_addr + 64'(m_off);
        exp_q.push_back({a, 8'(c)});
        if (a == err_addr) begin err = 1; break; end
        m_off += 32'(c); moved += c; rem -= c;
      end
    end
    comp = m_valid && !nf && (m_len == 0 || m_off >= m_len);
    irq = comp && m_ioc;

    @(negedge clk);
    list_base = base; start_idx = IW'(idx); req_bytes = LW'(req); resume = res; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!nf) chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    while (!done && n < 1000) begin
      if (glitch && n == 2) begin
        list_base = '0; resume = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; list_base = base;
      end else @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R11", "done reached", done, 1);
    chk(busy == 1'b0, "R11", "busy low at done", busy, 0);
    chk(not_found == nf, "R2", "not_found", not_found, nf);
    chk(xfer_err == err, "R10", "xfer_err", xfer_err, err);
    chk(xfer_bytes == LW'(moved), "R5", "xfer_bytes", xfer_bytes, moved);
    chk(desc_complete == comp, "R8", "desc_complete", desc_complete, comp);
    chk(irq_needed == irq, "R9", "irq_needed", irq_needed, irq);
    chk(cur_index == IW'(m_idx), "R3", "cur_index", cur_index, m_idx);
    chk(exp_q.size() == 0, "R6", "requests left over", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
  endtask

  initial begin
    d_addr[0] = 64'h0000_0001_0000_0040; d_len[0] = 40; d_ioc[0] = 1;
    d_addr[1] = 64'h8000;                d_len[1] = 0;  d_ioc[1] = 1;
    d_addr[2] = 64'h9000;                d_len[2] = 20; d_ioc[2] = 0;
    d_addr[3] = 64'hA000;                d_len[3] = 64; d_ioc[3] = 1;
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
    for (int i = 0; i < 4; i++) begin
      mem[i*4]   = d_addr[i][31:0];
      mem[i*4+1] = d_addr[i][63:32];
      mem[i*4+2] = d_len[i];
      mem[i*4+3] = 32'hFFFF_FFF0 | 32'(d_ioc[i]);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
    chk(xfer_bytes == 0, "R1", "xfer_bytes after reset", xfer_bytes, 0);

    run(64'h0, 0, 32, 0, 0);            // R2 zero base
    slow = 1'b1;
    run(BASE, 0, 100, 0, 1);            // R3 R5 R6 R8 R9, R11 start ignored while busy
    slow = 1'b0;
    run(BASE, 3, 20, 0, 0);             // R5 partial, not complete
    run(BASE, 3, 30, 1, 0);             // R7 resume from offset 20
    slow = 1'b1;
    run(BASE, 3, 100, 1, 0);            // R7 R5 clip to remaining 14, complete
    slow = 1'b0;
    run(BASE, 3, 5, 1, 0);              // R5 nothing left: zero bytes, complete
    run(BASE, 1, 50, 0, 0);             // R8 zero-length descriptor
    run(BASE, 2, 20, 0, 0);             // R9 complete without flag
    err_addr = 64'hA010;
    run(BASE, 3, 64, 0, 0);             // R4 offset reset, R10 error on second chunk
    err_addr = BASE + 64'd40;
    run(BASE, 2, 20, 0, 0);             // R10 error during descriptor read
    err_addr = '1;
    run(BASE, 3, 64, 0, 0);             // R4 fresh fetch full buffer
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule